// File: doc/BRIEF.md
# Scatter-Gather DMA Write Engine

This engine drains 256-bit words from a first-word-fall-through input FIFO on the user side and writes them into host or GPU memory through a simple in-order write-request channel. Destination memory is described by a small table of physical bus addresses. Each entry has its own length in words, and software may rewrite the table while a transfer runs. The engine treats every destination as a plain bus address, so system memory and GPU memory regions are handled in the same way.

Software programs the table, a per-request payload limit, a transfer length and a notification address through a word-addressed register port, and then issues a start command. The engine cuts the stream into write requests that never exceed the payload limit and never straddle two table entries. Once the last data beat has been accepted, it posts one notification write carrying the number of bytes moved. Software acknowledges with a stop command. A cycle counter runs from start to stop, so software can read the round-trip time at one-clock resolution. A stop issued mid-transfer lets the request already under way finish and then abandons the rest.

Top module: `sg_dma_writer`

## Requirements
- R1: After reset the status reads idle (0), `req_valid` and `fifo_rd` are low, and both the latency and byte-count registers read 0.
- R2: Each data request carries n words, with n = min(payload limit, words left in the current entry, words left in the transfer). `req_bytes` = 32·n. Its address is the entry base plus 32 bytes for every word already written from that entry. `req_sop` marks beat 0 and `req_eop` marks beat n-1.
- R3: The engine starts each transfer at entry 0 and walks the entries in ascending index order. It skips entries of length 0 and wraps from the last entry back to entry 0.
- R4: A data request starts only when `fifo_count` is at least n. Its beats carry the FIFO words in order, and `fifo_rd` is high exactly on accepted data beats.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_bytes`, `req_sop` and `req_data` hold their values.
- R6: After the last data beat the engine sends one single-beat request (sop and eop both high) to the notification address. That request has `req_bytes` = 32 and carries the bytes written in data bits 31:0. The status then reads done (2).
- R7: A stop command in done returns the status to idle. A stop while a data request is outstanding lets that request finish, suppresses all further data and the notification, and leaves the status idle.
- R8: The latency register holds the number of clock edges from the edge that accepts start up to the edge that accepts stop. It counts up while running, holds after stop, and restarts from 0 on the next start.
- R9: The byte-count register equals 32 times the number of data beats accepted since the last start.
- R10: A table entry rewritten during a transfer takes effect when the engine next loads that entry.
- R11: A start with transfer length 0 produces the notification at once, with byte count 0.
- R12: Register offsets on `pio_addr`:
  - 0: write bit0 = start, bit1 = stop; read gives status (0 idle, 1 busy, 2 done).
  - 1: transfer length in words.
  - 2: payload limit in words (0 is treated as 1).
  - 3 and 4: notification address, low and high halves.
  - 5: table entry select.
  - 6 and 7: selected entry address, low and high halves.
  - 8: selected entry length in words.
  - 9: bytes written.
  - 10: latency.
  - Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | input | 256 | Head word of the user FIFO |
| fifo_count | input | 8 | Words held in the user FIFO |
| fifo_rd | output | 1 | Pop the head word |
| pio_wr | input | 1 | Register write strobe |
| pio_addr | input | 4 | Register offset |
| pio_wdata | input | 32 | Register write data |
| pio_rdata | output | 32 | Register read data |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Request beat accepted |
| req_sop | output | 1 | First beat of a request |
| req_eop | output | 1 | Last beat of a request |
| req_addr | output | 64 | Request bus address |
| req_bytes | output | 16 | Request payload in bytes |
| req_data | output | 256 | Beat payload |

## Verification
Register reads are combinational, so the bench samples them two time units after the falling edge in the same cycle. Start and stop take effect on the rising edge that samples the strobe. The first request of a transfer therefore appears no earlier than three edges later: one to load the entry, one to size the request against the FIFO level, and one to raise valid. Each beat is judged on the falling edge before the rising edge that accepts it, and the bench's FIFO pops on that same rising edge. The bench computes latency from its own edge counter as the distance between the start and stop edges. While running, it expects the edges seen since start, minus one.

// File: rtl/sg_dma_writer.sv
module sg_dma_writer #(
  parameter int TBL_N = 8,
  parameter int LEN_W = 27,
  parameter int CNT_W = 8,
  parameter int MPS_W = 4,
  parameter int AW    = 64,
  parameter int DW    = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    fifo_data,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             fifo_rd,
  input  logic             pio_wr,
  input  logic [3:0]       pio_addr,
  input  logic [31:0]      pio_wdata,
  output logic [31:0]      pio_rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_sop,
  output logic             req_eop,
  output logic [AW-1:0]    req_addr,
  output logic [15:0]      req_bytes,
  output logic [DW-1:0]    req_data
);
  localparam int IDX_W  = (TBL_N > 1) ? $clog2(TBL_N) : 1;
  localparam int BEAT_B = DW / 8;
  localparam int SH     = $clog2(BEAT_B);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_PLAN, S_SEND, S_NOTE, S_DONE} st_t;
  st_t st;

  logic [31:0]      total_len, tot_rem, words_done, lat_cnt, req_n, beat;
  logic [MPS_W-1:0] mps;
  logic [AW-1:0]    note_addr, cur_addr;
  logic [IDX_W-1:0] sel, idx;
  logic [LEN_W-1:0] ent_rem;
  logic             abort, lat_run;
  logic [AW-1:0]    tbl_addr [TBL_N];
  logic [LEN_W-1:0] tbl_len  [TBL_N];

  wire ctrl_wr   = pio_wr && (pio_addr == 4'd0);
  wire can_start = (st == S_IDLE) || (st == S_DONE);
  wire start_ok  = ctrl_wr && pio_wdata[0] && can_start;
  wire stop_cmd  = ctrl_wr && pio_wdata[1];
  wire abort_now = abort || stop_cmd;
  wire in_note   = (st == S_NOTE);
  wire in_send   = (st == S_SEND);
  wire beat_go   = in_send && req_ready;
  wire last_beat = (beat == req_n - 32'd1);

  wire [IDX_W-1:0] idx_nxt = (idx == IDX_W'(TBL_N - 1)) ? '0 : idx + IDX_W'(1);
  wire [31:0] mps_eff    = (mps == '0) ? 32'd1 : 32'(mps);
  wire [31:0] ent_w      = 32'(ent_rem);
  wire [31:0] lim_ent    = (ent_w < mps_eff) ? ent_w : mps_eff;
  wire [31:0] n_next     = (tot_rem < lim_ent) ? tot_rem : lim_ent;
  wire [31:0] bytes_done = words_done << SH;
  wire [1:0]  stat       = (st == S_IDLE) ? 2'd0 : (st == S_DONE) ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_len <= '0;
      mps       <= MPS_W'(1);
      note_addr <= '0;
      sel       <= '0;
      for (int i = 0; i < TBL_N; i++) begin
        tbl_addr[i] <= '0;
        tbl_len[i]  <= '0;
      end
    end else if (pio_wr) begin
      case (pio_addr)
        4'd1: total_len <= pio_wdata;
        4'd2: mps <= pio_wdata[MPS_W-1:0];
        4'd3: note_addr[31:0] <= pio_wdata;
        4'd4: note_addr[63:32] <= pio_wdata;
        4'd5: sel <= pio_wdata[IDX_W-1:0];
        4'd6: tbl_addr[sel][31:0] <= pio_wdata;
        4'd7: tbl_addr[sel][63:32] <= pio_wdata;
        4'd8: tbl_len[sel] <= pio_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_run <= 1'b0;
    end else if (start_ok) begin
      lat_cnt <= '0;
      lat_run <= 1'b1;
    end else if (lat_run) begin
      lat_cnt <= lat_cnt + 32'd1;
      if (stop_cmd) lat_run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      cur_addr   <= '0;
      ent_rem    <= '0;
      tot_rem    <= '0;
      words_done <= '0;
      req_n      <= '0;
      beat       <= '0;
      abort      <= 1'b0;
    end else begin
      if (stop_cmd && !can_start) abort <= 1'b1;
      case (st)
        S_IDLE, S_DONE: begin
          if (start_ok) begin
            tot_rem    <= total_len;
            idx        <= '0;
            words_done <= '0;
            abort      <= 1'b0;
            st         <= S_LOAD;
          end else if (st == S_DONE && stop_cmd) begin
            st <= S_IDLE;
          end
        end
        S_LOAD: begin
          if (abort_now)                 st <= S_IDLE;
          else if (tot_rem == '0)        st <= S_NOTE;
          else if (tbl_len[idx] == '0)   idx <= idx_nxt;
          else begin
            cur_addr <= tbl_addr[idx];
            ent_rem  <= tbl_len[idx];
            st       <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (abort_now) st <= S_IDLE;
          else if (32'(fifo_count) >= n_next) begin
            req_n <= n_next;
            beat  <= '0;
            st    <= S_SEND;
          end
        end
        S_SEND: begin
          if (beat_go) begin
            beat <= beat + 32'd1;
            if (last_beat) begin
              cur_addr   <= cur_addr + (AW'(req_n) << SH);
              ent_rem    <= ent_rem - LEN_W'(req_n);
              tot_rem    <= tot_rem - req_n;
              words_done <= words_done + req_n;
              if (abort_now)              st <= S_IDLE;
              else if (tot_rem == req_n)  st <= S_NOTE;
              else if (ent_w == req_n) begin
                idx <= idx_nxt;
                st  <= S_LOAD;
              end else                    st <= S_PLAN;
            end
          end
        end
        S_NOTE: if (req_ready) st <= abort_now ? S_IDLE : S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_valid = in_send || in_note;
  assign req_sop   = in_note || (beat == '0);
  assign req_eop   = in_note || last_beat;
  assign req_addr  = in_note ? note_addr : cur_addr;
  assign req_bytes = in_note ? 16'(BEAT_B) : 16'(req_n << SH);
  assign req_data  = in_note ? DW'(bytes_done) : fifo_data;
  assign fifo_rd   = beat_go;

  always_comb begin
    case (pio_addr)
      4'd0:    pio_rdata = {30'd0, stat};
      4'd1:    pio_rdata = total_len;
      4'd2:    pio_rdata = 32'(mps);
      4'd3:    pio_rdata = note_addr[31:0];
      4'd4:    pio_rdata = note_addr[63:32];
      4'd5:    pio_rdata = 32'(sel);
      4'd6:    pio_rdata = tbl_addr[sel][31:0];
      4'd7:    pio_rdata = tbl_addr[sel][63:32];
      4'd8:    pio_rdata = 32'(tbl_len[sel]);
      4'd9:    pio_rdata = bytes_done;
      4'd10:   pio_rdata = lat_cnt;
      default: pio_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sg_dma_writer_chk.sv
module sg_dma_writer_chk #(
  parameter int AW    = 64,
  parameter int DW    = 256,
  parameter int CNT_W = 8,
  parameter int MPS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_sop,
  input logic             req_eop,
  input logic [AW-1:0]    req_addr,
  input logic [15:0]      req_bytes,
  input logic [DW-1:0]    req_data,
  input logic             fifo_rd,
  input logic [CNT_W-1:0] fifo_count,
  input logic             in_note,
  input logic [MPS_W-1:0] mps,
  input logic             lat_run,
  input logic             start_ok,
  input logic [31:0]      lat_cnt
);
  localparam int SH = $clog2(DW / 8);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
                               && $stable(req_sop) && $stable(req_bytes));

  a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> req_valid && req_ready && !in_note);

  a_r4_level: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sop && !in_note |-> 32'(fifo_count) >= 32'(req_bytes >> SH));

  a_r2_size: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sop && !in_note |->
      req_bytes != 16'd0 && 32'(req_bytes) <= (((mps == '0) ? 32'd1 : 32'(mps)) << SH));

  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_note |-> req_sop && req_eop);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_run && !start_ok |=> $stable(lat_cnt));
endmodule

bind sg_dma_writer sg_dma_writer_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .MPS_W(MPS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sop(req_sop), .req_eop(req_eop), .req_addr(req_addr), .req_bytes(req_bytes),
  .req_data(req_data), .fifo_rd(fifo_rd), .fifo_count(fifo_count), .in_note(in_note),
  .mps(mps), .lat_run(lat_run), .start_ok(start_ok), .lat_cnt(lat_cnt)
);

// File: tb/sim_sg_dma_writer.sv
module sim_sg_dma_writer;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [255:0] fifo_data;
  logic [7:0]   fifo_count;
  logic         fifo_rd, pio_wr = 1'b0, req_valid, req_ready = 1'b0, req_sop, req_eop;
  logic [3:0]   pio_addr = 4'd0;
  logic [31:0]  pio_wdata = '0, pio_rdata;
  logic [63:0]  req_addr;
  logic [15:0]  req_bytes;
  logic [255:0] req_data;

  sg_dma_writer u0 (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_count(fifo_count), .fifo_rd(fifo_rd),
    .pio_wr(pio_wr), .pio_addr(pio_addr), .pio_wdata(pio_wdata), .pio_rdata(pio_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_sop(req_sop), .req_eop(req_eop),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_data(req_data)
  );

  int cyc = 0, checks = 0, fails = 0;
  int rp = 0, wp = 0, feed_left = 0, feed_gap = 1, rdy_mode = 0;
  logic push = 1'b0;

  function automatic logic [255:0] mkword(input int k);
    mkword = {8{32'hC0DE0000 + 32'(k)}};
  endfunction

  assign fifo_data  = mkword(rp);
  assign fifo_count = 8'(wp - rp);

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    if (fifo_rd) rp <= rp + 1;
    if (push) begin
      wp <= wp + 1;
      feed_left <= feed_left - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [63:0] b_addr [8];
  int          b_len  [8];
  int          b_mps = 1, b_total = 0;
  logic [63:0] b_note = 64'h0000_00F0_0000_0400;
  logic [63:0] e_addr [64];
  int          e_n    [64];
  int          e_cnt = 0, ri = 0, bi = 0, wi = 0;
  bit          note_seen = 1'b0;

  initial for (int i = 0; i < 8; i++) begin b_addr[i] = '0; b_len[i] = 0; end

  task automatic make_plan();
    int idx, rem, tot, lim, n;
    logic [63:0] a;
    lim = (b_mps == 0) ? 1 : b_mps;
    idx = 0; rem = b_len[0]; a = b_addr[0]; tot = b_total;
    e_cnt = 0; ri = 0; bi = 0; note_seen = 1'b0;
    while (tot > 0) begin
      while (rem == 0) begin idx = (idx + 1) % 8; rem = b_len[idx]; a = b_addr[idx]; end
      n = lim;
      if (rem < n) n = rem;
      if (tot < n) n = tot;
      e_addr[e_cnt] = a; e_n[e_cnt] = n; e_cnt++;
      a = a + 64'(n * 32); rem -= n; tot -= n;
    end
  endtask

  logic        stalled = 1'b0, h_sop;
  logic [63:0] h_addr;
  logic [255:0] h_data;

  initial forever begin
    @(negedge clk);
    req_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 1) : 1'b0;
    push = (feed_left > 0) && (cyc % feed_gap == 0);
    #1;
    if (rst_n) begin
      if (stalled)
        chk(req_valid && req_addr == h_addr && req_data == h_data && req_sop == h_sop,
            "R5 hold under stall", req_addr, h_addr);
      stalled = req_valid && !req_ready;
      h_addr = req_addr; h_data = req_data; h_sop = req_sop;
      if (req_valid && req_ready) begin
        if (ri == e_cnt && req_sop) begin
          chk(req_addr == b_note, "R6 notify address", req_addr, b_note);
          chk(req_bytes == 16'd32 && req_eop, "R6 notify single beat", 64'(req_bytes), 64'd32);
          chk(req_data[31:0] == 32'(b_total * 32), "R6 notify bytes", 64'(req_data[31:0]), 64'(b_total * 32));
          note_seen = 1'b1;
          ri++;
        end else if (ri >= e_cnt) begin
          chk(1'b0, "R7 unexpected request", req_addr, 64'd0);
        end else begin
          if (bi == 0) begin
            chk(req_sop, "R2 sop on first beat", 64'(req_sop), 64'd1);
            chk(req_addr == e_addr[ri], "R2 R3 request address", req_addr, e_addr[ri]);
            chk(req_bytes == 16'(e_n[ri] * 32), "R2 request bytes", 64'(req_bytes), 64'(e_n[ri] * 32));
            chk(32'(fifo_count) >= 32'(e_n[ri]), "R4 fifo level at start", 64'(fifo_count), 64'(e_n[ri]));
          end
          chk(req_data == mkword(wi), "R4 beat data", req_data[63:0], mkword(wi) >> 192);
          chk(fifo_rd, "R4 pop on beat", 64'(fifo_rd), 64'd1);
          wi++;
          if (bi == e_n[ri] - 1) begin
            chk(req_eop, "R2 eop on last beat", 64'(req_eop), 64'd1);
            bi = 0; ri++;
          end else bi++;
        end
      end
    end
  end

  task automatic pio_write(input logic [3:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    pio_addr = a; pio_wdata = d; pio_wr = 1'b1;
    @(posedge clk);
    at = cyc;
    @(negedge clk);
    pio_wr = 1'b0;
  endtask

  task automatic pio_read(input logic [3:0] a, output logic [31:0] d, output int at);
    @(negedge clk);
    pio_addr = a;
    #2;
    d = pio_rdata; at = cyc;
  endtask

  task automatic tbl_write(input int i, input logic [63:0] a, input int len);
    int t;
    pio_write(4'd5, 32'(i), t);
    pio_write(4'd6, a[31:0], t);
    pio_write(4'd7, a[63:32], t);
    pio_write(4'd8, 32'(len), t);
    b_addr[i] = a; b_len[i] = len;
  endtask

  task automatic wait_status(input logic [31:0] want, input string tag);
    logic [31:0] v;
    int t;
    v = '1;
    for (int k = 0; k < 3000; k++) begin
      pio_read(4'd0, v, t);
      if (v == want) break;
    end
    chk(v == want, tag, 64'(v), 64'(want));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s, s2, t;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    chk(!req_valid && !fifo_rd, "R1 outputs quiet", 64'(req_valid), 64'd0);
    pio_read(4'd0, v, t);  chk(v == 0, "R1 status idle", 64'(v), 64'd0);
    pio_read(4'd10, v, t); chk(v == 0, "R1 latency zero", 64'(v), 64'd0);
    pio_read(4'd9, v, t);  chk(v == 0, "R1 bytes zero", 64'(v), 64'd0);

    pio_write(4'd3, b_note[31:0], t);
    pio_write(4'd4, b_note[63:32], t);
    pio_read(4'd4, v, t); chk(v == b_note[63:32], "R12 notify address readback", 64'(v), 64'(b_note[63:32]));

    // T1: three entries, payload 4, prefilled FIFO
    tbl_write(0, 64'hFFFF_FFFF_0000_1000, 5);
    tbl_write(1, 64'h0000_0000_0000_2000, 3);
    tbl_write(2, 64'h0000_0000_8000_0000, 9);
    pio_write(4'd2, 32'd4, t);  b_mps = 4;
    pio_write(4'd1, 32'd17, t); b_total = 17;
    make_plan();
    feed_gap = 1; feed_left = 17;
    repeat (22) @(negedge clk);
    pio_write(4'd0, 32'd1, s);
    wait_status(32'd2, "R6 done after transfer");
    chk(note_seen, "R6 notification seen", 64'(note_seen), 64'd1);
    chk(ri == e_cnt + 1, "R2 all requests seen", 64'(ri), 64'(e_cnt + 1));
    pio_read(4'd9, v, t); chk(v == 32'd544, "R9 bytes written", 64'(v), 64'd544);
    pio_write(4'd0, 32'd2, s2);
    pio_read(4'd0, v, t);  chk(v == 0, "R7 stop in done gives idle", 64'(v), 64'd0);
    pio_read(4'd10, v, t); chk(v == 32'(s2 - s), "R8 latency", 64'(v), 64'(s2 - s));
    repeat (7) @(negedge clk);
    pio_read(4'd10, v, t); chk(v == 32'(s2 - s), "R8 latency holds", 64'(v), 64'(s2 - s));

    // T2: wrap with a skipped entry, slow feed, backpressure
    for (int i = 0; i < 8; i++) tbl_write(i, 64'h0000_0040_0000_0000 + 64'(i) * 64'h1_0000, (i == 3) ? 0 : 2);
    pio_write(4'd2, 32'd8, t);  b_mps = 8;
    pio_write(4'd1, 32'd20, t); b_total = 20;
    make_plan();
    rdy_mode = 1; feed_gap = 3; feed_left = 20;
    pio_write(4'd0, 32'd1, s);
    pio_read(4'd10, v, t); chk(v == 32'(t - s - 1), "R8 latency restarts and runs", 64'(v), 64'(t - s - 1));
    wait_status(32'd2, "R3 done after wrapped transfer");
    chk(note_seen && ri == e_cnt + 1, "R3 wrapped request count", 64'(ri), 64'(e_cnt + 1));
    pio_read(4'd9, v, t); chk(v == 32'd640, "R9 bytes written", 64'(v), 64'd640);
    pio_write(4'd0, 32'd2, t);
    rdy_mode = 0;

    // T5: zero-length transfer
    pio_write(4'd1, 32'd0, t); b_total = 0;
    make_plan();
    pio_write(4'd0, 32'd1, s);
    wait_status(32'd2, "R11 done with zero length");
    chk(note_seen, "R11 notification for zero length", 64'(note_seen), 64'd1);
    pio_read(4'd9, v, t); chk(v == 0, "R11 bytes zero", 64'(v), 64'd0);
    pio_write(4'd0, 32'd2, t);

    // T4: rewrite an entry while running
    tbl_write(0, 64'h0000_0000_0001_0000, 4);
    tbl_write(1, 64'h0000_0000_0002_0000, 4);
    pio_write(4'd2, 32'd2, t); b_mps = 2;
    pio_write(4'd1, 32'd8, t); b_total = 8;
    pio_write(4'd0, 32'd1, s);
    repeat (5) @(negedge clk);
    tbl_write(1, 64'h0000_0077_0003_0000, 4);
    make_plan();
    pio_read(4'd7, v, t); chk(v == 32'h77, "R10 R12 rewritten entry readback", 64'(v), 64'h77);
    feed_gap = 1; feed_left = 8;
    wait_status(32'd2, "R10 done after rewrite");
    chk(note_seen && ri == e_cnt + 1, "R10 requests used new address", 64'(ri), 64'(e_cnt + 1));
    pio_write(4'd0, 32'd2, t);

    // T3: stop while a request is stalled
    tbl_write(0, 64'h0000_0000_0005_0000, 40);
    pio_write(4'd2, 32'd4, t);  b_mps = 4;
    pio_write(4'd1, 32'd40, t); b_total = 40;
    make_plan();
    rdy_mode = 2; feed_gap = 1; feed_left = 10;
    repeat (14) @(negedge clk);
    pio_write(4'd0, 32'd1, s);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk); #3;
      if (req_valid) break;
    end
    pio_write(4'd0, 32'd2, s2);
    rdy_mode = 0;
    repeat (60) @(negedge clk);
    chk(ri == 1, "R7 only the outstanding request completes", 64'(ri), 64'd1);
    chk(!note_seen, "R7 no notification after stop", 64'(note_seen), 64'd0);
    chk(fifo_count == 8'd6, "R7 remaining words stay in FIFO", 64'(fifo_count), 64'd6);
    pio_read(4'd0, v, t);  chk(v == 0, "R7 idle after stop", 64'(v), 64'd0);
    pio_read(4'd10, v, t); chk(v == 32'(s2 - s), "R8 latency on abort", 64'(v), 64'(s2 - s));

    summary();
    $finish;
  end
endmodule